// File: doc/BRIEF.md
# Cascaded Interrupt Priority Acknowledge Engine

This block keeps the request and in-service state of two chained 8-input interrupt controllers. One acts as the primary. The other, the secondary, feeds primary input 2. Devices send one-cycle assert and deassert pulses that name one of 16 lines. Lines 0 to 7 belong to the primary and lines 8 to 15 belong to the secondary. A per-controller edge/level register decides whether a deassert pulse may withdraw a request. A separate command block supplies the masks, the vector bases and the lowest-priority pointers as plain inputs.

When the processor is ready to take an interrupt, it pulses the acknowledge strobe. The engine searches the primary first, using a rotating priority order, and then the secondary. It retires the winning request into service and returns a 16-bit vector one cycle later. Masks are applied only during this search and in the combined pending flag. A request that arrives while its line is masked is therefore still latched and is not lost.

Top module: `cascade_ack_engine`

## Requirements
- R1: An assert pulse on line 0..7 sets primary request bit `line`, whatever the primary mask holds.
- R2: An assert pulse on line 8..15 sets secondary request bit `line-8` and primary request bit 2, whatever either mask holds.
- R3: Each controller's search begins at position (lowest-priority pointer + 1) mod 8 and wraps through all eight positions. The first eligible position found wins.
- R4: The primary is searched first, and its bit 2 is never eligible there. The secondary is searched only when no primary request is eligible, and the primary mask bit 2 plays no part in that search.
- R5: A primary win clears its request bit and sets its in-service bit. The result is primary base + index as a 16-bit sum with no 8-bit wrap (base 0xFE with index 7 gives 0x0105). In-service bits are cleared only by reset or by a clear.
- R6: A secondary win clears that secondary request bit and primary request bit 2. It sets that secondary in-service bit and primary in-service bit 2, and returns secondary base + index.
- R7: When no request is eligible, the acknowledge result is 0xFFFF.
- R8: A deassert pulse clears a request bit only when that line's edge/level bit is 1 (level). On a secondary line, primary request bit 2 is also cleared once the secondary request register becomes zero.
- R9: `pending` is 1 exactly when (primary request AND NOT (primary mask OR bit 2)) or (secondary request AND NOT secondary mask) is nonzero.
- R10: `ack_vld` is high, and `ack_vec` holds the result, in the cycle after `ack_stb`, and `ack_vld` is low otherwise. An assert or deassert in the same cycle as `ack_stb` is applied before the search.
- R11: `clr_pri` or `clr_sec` zeroes the request and in-service registers of that controller only, overriding every other update to that controller in the same cycle.
- R12: With `lvl_we` high, `lvl_din` is written to the primary edge/level register when `lvl_sel`=0 and to the secondary one when `lvl_sel`=1. Bit k governs line k of that controller.
- R13: After reset, all request and in-service bits and both edge/level registers are 0, `ack_vld` is 0 and `ack_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| assert_vld | input | 1 | Assert pulse |
| assert_line | input | 4 | Line number for the assert pulse |
| deassert_vld | input | 1 | Deassert pulse |
| deassert_line | input | 4 | Line number for the deassert pulse |
| lvl_we | input | 1 | Edge/level register write enable |
| lvl_sel | input | 1 | 0 primary, 1 secondary edge/level register |
| lvl_din | input | 8 | Edge/level write data, 1 = level |
| mask_pri | input | 8 | Primary mask |
| mask_sec | input | 8 | Secondary mask |
| base_pri | input | 8 | Primary vector base |
| base_sec | input | 8 | Secondary vector base |
| low_pri | input | 3 | Primary lowest-priority pointer |
| low_sec | input | 3 | Secondary lowest-priority pointer |
| clr_pri | input | 1 | Clear primary request and in-service state |
| clr_sec | input | 1 | Clear secondary request and in-service state |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_vec | output | 16 | Acknowledge vector, 0xFFFF when none |
| pending | output | 1 | Some unmasked request exists |
| req_pri | output | 8 | Primary request register |
| req_sec | output | 8 | Secondary request register |
| isr_pri | output | 8 | Primary in-service register |
| isr_sec | output | 8 | Secondary in-service register |

## Verification
The search is tried with requests on both ends of the ring under several pointer values. This separates a correct rotation start from an off-by-one or a fixed order. Mixed primary and secondary requests, with the primary line or primary bit 2 masked, separate primary-first ordering from a plain 16-bit search, and show whether the bit-2 mask is wrongly applied to the secondary. Masked-only and empty patterns separate the 0xFFFF answer from a stale vector. Deasserts on edge and level lines, a same-cycle assert and acknowledge, and a one-sided clear show that updates are ordered as specified and that each controller's state stays separate.

// File: rtl/cae_pkg.sv
package cae_pkg;
  localparam int unsigned CTL_INPUTS   = 8;
  localparam int unsigned CASCADE_IN   = 2;
  localparam int unsigned BASE_WIDTH   = 8;
  localparam int unsigned RESULT_WIDTH = 16;
  localparam logic [RESULT_WIDTH-1:0] NO_VECTOR = '1;
endpackage

// File: rtl/cae_prio_pick.sv
// Rotating priority picker: search starts just above the lowest-priority slot.
module cae_prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] low,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [IW-1:0]  start;
  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;
  logic [IW-1:0]  pos;

  assign start = low + 1'b1;
  assign dbl   = {cand, cand} >> start;
  assign rot   = dbl[N-1:0];

  always_comb begin
    pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) pos = IW'(i);
    end
  end

  assign found = |rot;
  assign idx   = start + pos;
endmodule

// File: rtl/cae_lvl_bank.sv
// Edge/level control registers, one per controller.
module cae_lvl_bank #(
  parameter int unsigned N     = 8,
  parameter int unsigned BANKS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         sel,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl [BANKS]
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) lvl[b] <= '0;
      else if (we && (sel == 1'(b))) lvl[b] <= din;
    end
  end
endmodule

// File: rtl/cascade_ack_engine.sv
module cascade_ack_engine
  import cae_pkg::*;
#(
  parameter int unsigned N       = CTL_INPUTS,
  parameter int unsigned CASC_IN = CASCADE_IN,
  parameter int unsigned BASE_W  = BASE_WIDTH,
  parameter int unsigned RES_W   = RESULT_WIDTH,
  localparam int unsigned IDX_W  = $clog2(N),
  localparam int unsigned LINE_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              assert_vld,
  input  logic [LINE_W-1:0] assert_line,
  input  logic              deassert_vld,
  input  logic [LINE_W-1:0] deassert_line,
  input  logic              lvl_we,
  input  logic              lvl_sel,
  input  logic [N-1:0]      lvl_din,
  input  logic [N-1:0]      mask_pri,
  input  logic [N-1:0]      mask_sec,
  input  logic [BASE_W-1:0] base_pri,
  input  logic [BASE_W-1:0] base_sec,
  input  logic [IDX_W-1:0]  low_pri,
  input  logic [IDX_W-1:0]  low_sec,
  input  logic              clr_pri,
  input  logic              clr_sec,
  input  logic              ack_stb,
  output logic              ack_vld,
  output logic [RES_W-1:0]  ack_vec,
  output logic              pending,
  output logic [N-1:0]      req_pri,
  output logic [N-1:0]      req_sec,
  output logic [N-1:0]      isr_pri,
  output logic [N-1:0]      isr_sec
);
  localparam logic [N-1:0]     CASC_BIT = N'(1) << CASC_IN;
  localparam logic [RES_W-1:0] NONE     = RES_W'(NO_VECTOR);

  logic [N-1:0]     lvl [2];
  logic [N-1:0]     a_pri, a_sec, n_pri, n_sec, ni_pri, ni_sec;
  logic [N-1:0]     cand_pri, cand_sec;
  logic             f_pri, f_sec;
  logic [IDX_W-1:0] i_pri, i_sec, ai, di;
  logic [RES_W-1:0] res;

  cae_lvl_bank #(.N(N), .BANKS(2)) u_lvl (
    .clk(clk), .rst(rst), .we(lvl_we), .sel(lvl_sel), .din(lvl_din), .lvl(lvl)
  );

  assign ai = assert_line[IDX_W-1:0];
  assign di = deassert_line[IDX_W-1:0];

  // Stage 1: line events, assert before deassert.
  always_comb begin
    a_pri = req_pri;
    a_sec = req_sec;
    if (assert_vld) begin
      if (assert_line[IDX_W]) begin
        a_sec[ai] = 1'b1;
        a_pri     = a_pri | CASC_BIT;
      end else begin
        a_pri[ai] = 1'b1;
      end
    end
    if (deassert_vld) begin
      if (deassert_line[IDX_W]) begin
        if (lvl[1][di]) begin
          a_sec[di] = 1'b0;
          if (a_sec == '0) a_pri = a_pri & ~CASC_BIT;
        end
      end else if (lvl[0][di]) begin
        a_pri[di] = 1'b0;
      end
    end
  end

  // Stage 2: masked search, primary first.
  assign cand_pri = a_pri & ~mask_pri & ~CASC_BIT;
  assign cand_sec = a_sec & ~mask_sec;

  cae_prio_pick #(.N(N)) u_pick_pri (.cand(cand_pri), .low(low_pri), .found(f_pri), .idx(i_pri));
  cae_prio_pick #(.N(N)) u_pick_sec (.cand(cand_sec), .low(low_sec), .found(f_sec), .idx(i_sec));

  always_comb begin
    n_pri  = a_pri;
    n_sec  = a_sec;
    ni_pri = isr_pri;
    ni_sec = isr_sec;
    res    = NONE;
    if (ack_stb) begin
      if (f_pri) begin
        n_pri[i_pri]  = 1'b0;
        ni_pri[i_pri] = 1'b1;
        res = RES_W'(base_pri) + RES_W'(i_pri);
      end else if (f_sec) begin
        n_sec[i_sec]  = 1'b0;
        ni_sec[i_sec] = 1'b1;
        n_pri  = n_pri & ~CASC_BIT;
        ni_pri = ni_pri | CASC_BIT;
        res = RES_W'(base_sec) + RES_W'(i_sec);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_pri <= '0;
      req_sec <= '0;
      isr_pri <= '0;
      isr_sec <= '0;
      ack_vld <= 1'b0;
      ack_vec <= '0;
    end else begin
      req_pri <= clr_pri ? '0 : n_pri;
      isr_pri <= clr_pri ? '0 : ni_pri;
      req_sec <= clr_sec ? '0 : n_sec;
      isr_sec <= clr_sec ? '0 : ni_sec;
      ack_vld <= ack_stb;
      if (ack_stb) ack_vec <= res;
    end
  end

  assign pending = (|(req_pri & ~(mask_pri | CASC_BIT))) || (|(req_sec & ~mask_sec));
endmodule

// File: rtl/cae_checker.sv
module cae_checker #(
  parameter int unsigned N     = 8,
  parameter int unsigned LW    = 4,
  parameter int unsigned RES_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             assert_vld,
  input logic [LW-1:0]    assert_line,
  input logic             deassert_vld,
  input logic             clr_pri,
  input logic             clr_sec,
  input logic             ack_stb,
  input logic             ack_vld,
  input logic [RES_W-1:0] ack_vec,
  input logic             pending,
  input logic [N-1:0]     req_pri,
  input logic [N-1:0]     req_sec,
  input logic [N-1:0]     isr_pri,
  input logic [N-1:0]     isr_sec
);
  a_r1_assert_latches: assert property (@(posedge clk) disable iff (rst)
    assert_vld && !assert_line[LW-1] && !deassert_vld && !ack_stb && !clr_pri
    |=> req_pri[$past(assert_line[LW-2:0])]);

  a_r2_sec_mirrors: assert property (@(posedge clk) disable iff (rst)
    assert_vld && assert_line[LW-1] && !deassert_vld && !ack_stb && !clr_pri && !clr_sec
    |=> req_pri[2] && req_sec[$past(assert_line[LW-2:0])]);

  a_r5_isr_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_pri |=> (($past(isr_pri) & ~isr_pri) == '0));

  a_r5_ack_in_service: assert property (@(posedge clk) disable iff (rst)
    ack_vld && (ack_vec != '1) && !$past(clr_pri) |-> (isr_pri != '0));

  a_r7_none_when_idle: assert property (@(posedge clk) disable iff (rst)
    ack_stb && !pending && !assert_vld |=> (ack_vec == '1));

  a_r9_pending_needs_req: assert property (@(posedge clk) disable iff (rst)
    pending |-> ((req_pri | req_sec) != '0));

  a_r10_vld_follows: assert property (@(posedge clk) disable iff (rst)
    ack_stb |=> ack_vld);

  a_r10_vld_pulse: assert property (@(posedge clk) disable iff (rst)
    !ack_stb |=> !ack_vld);

  a_r11_clear_sec: assert property (@(posedge clk) disable iff (rst)
    clr_sec |=> (req_sec == '0) && (isr_sec == '0));
endmodule

bind cascade_ack_engine cae_checker #(.N(N), .LW(LINE_W), .RES_W(RES_W)) u_cae_checker (
  .clk(clk), .rst(rst), .assert_vld(assert_vld), .assert_line(assert_line),
  .deassert_vld(deassert_vld), .clr_pri(clr_pri), .clr_sec(clr_sec),
  .ack_stb(ack_stb), .ack_vld(ack_vld), .ack_vec(ack_vec), .pending(pending),
  .req_pri(req_pri), .req_sec(req_sec), .isr_pri(isr_pri), .isr_sec(isr_sec)
);

// File: tb/cascade_ack_engine_bench.sv
module cascade_ack_engine_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic assert_vld = 0, deassert_vld = 0, lvl_we = 0, lvl_sel = 0;
  logic [3:0] assert_line = 0, deassert_line = 0;
  logic [7:0] lvl_din = 0, mask_pri = 0, mask_sec = 0, base_pri = 8'h20, base_sec = 8'h28;
  logic [2:0] low_pri = 3'd7, low_sec = 3'd7;
  logic clr_pri = 0, clr_sec = 0, ack_stb = 0;
  logic ack_vld, pending;
  logic [15:0] ack_vec;
  logic [7:0] req_pri, req_sec, isr_pri, isr_sec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cascade_ack_engine u_cascade_ack_engine (
    .clk(clk), .rst(rst), .assert_vld(assert_vld), .assert_line(assert_line),
    .deassert_vld(deassert_vld), .deassert_line(deassert_line),
    .lvl_we(lvl_we), .lvl_sel(lvl_sel), .lvl_din(lvl_din),
    .mask_pri(mask_pri), .mask_sec(mask_sec), .base_pri(base_pri), .base_sec(base_sec),
    .low_pri(low_pri), .low_sec(low_sec), .clr_pri(clr_pri), .clr_sec(clr_sec),
    .ack_stb(ack_stb), .ack_vld(ack_vld), .ack_vec(ack_vec), .pending(pending),
    .req_pri(req_pri), .req_sec(req_sec), .isr_pri(isr_pri), .isr_sec(isr_sec)
  );

  typedef struct packed {
    logic [15:0] lines;
    logic [7:0]  mp;
    logic [7:0]  ms;
    logic [2:0]  lp;
    logic [2:0]  ls;
    logic [15:0] ex;
  } tv_t;

  localparam tv_t TV [12] = '{
    '{16'h0001, 8'h00, 8'h00, 3'd7, 3'd7, 16'h0020},
    '{16'h0081, 8'h00, 8'h00, 3'd6, 3'd7, 16'h0027},
    '{16'h0081, 8'h00, 8'h00, 3'd7, 3'd7, 16'h0020},
    '{16'h0011, 8'h00, 8'h00, 3'd2, 3'd7, 16'h0024},
    '{16'h0001, 8'h01, 8'h00, 3'd7, 3'd7, 16'hFFFF},
    '{16'h0100, 8'h00, 8'h00, 3'd7, 3'd7, 16'h0028},
    '{16'h0102, 8'h00, 8'h00, 3'd7, 3'd7, 16'h0021},
    '{16'h0102, 8'h02, 8'h00, 3'd7, 3'd7, 16'h0028},
    '{16'h8100, 8'h00, 8'h00, 3'd7, 3'd6, 16'h002F},
    '{16'h0100, 8'h04, 8'h00, 3'd7, 3'd7, 16'h0028},
    '{16'h0100, 8'h00, 8'h01, 3'd7, 3'd7, 16'hFFFF},
    '{16'h0000, 8'h00, 8'h00, 3'd7, 3'd7, 16'hFFFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_assert(input logic [3:0] line);
    assert_vld = 1; assert_line = line;
    @(negedge clk);
    assert_vld = 0;
  endtask

  task automatic do_deassert(input logic [3:0] line);
    deassert_vld = 1; deassert_line = line;
    @(negedge clk);
    deassert_vld = 0;
  endtask

  task automatic do_ack;
    ack_stb = 1;
    @(negedge clk);
    ack_stb = 0;
  endtask

  task automatic clear_both;
    clr_pri = 1; clr_sec = 1;
    @(negedge clk);
    clr_pri = 0; clr_sec = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R13 reset state
    chk("R13 ack_vld", ack_vld, 0);
    chk("R13 ack_vec", ack_vec, 0);
    chk("R13 req/isr", {req_pri, req_sec, isr_pri, isr_sec}, 0);
    chk("R13 pending", pending, 0);

    // Table walk: R3 R4 R5 R6 R7 R9
    for (int k = 0; k < 12; k++) begin
      clear_both();
      mask_pri = TV[k].mp; mask_sec = TV[k].ms;
      low_pri = TV[k].lp; low_sec = TV[k].ls;
      for (int b = 0; b < 16; b++) if (TV[k].lines[b]) do_assert(4'(b));
      chk("R9 pending", pending, TV[k].ex != 16'hFFFF);
      do_ack();
      chk("R3/R4/R7 vector", ack_vec, TV[k].ex);
    end
    mask_pri = 0; mask_sec = 0; low_pri = 7; low_sec = 7;

    // R1: masked assert still latched
    clear_both();
    mask_pri = 8'h08;
    do_assert(4'd3);
    chk("R1 masked latch", req_pri, 8'h08);
    mask_pri = 0;
    // R5 primary ack state
    do_ack();
    chk("R5 req cleared", req_pri, 8'h00);
    chk("R5 isr set", isr_pri, 8'h08);
    chk("R10 vld high", ack_vld, 1);
    @(negedge clk);
    chk("R10 vld one pulse", ack_vld, 0);

    // R2 and R6
    clear_both();
    do_assert(4'd13);
    chk("R2 mirror", {req_pri, req_sec}, {8'h04, 8'h20});
    do_ack();
    chk("R6 vector", ack_vec, 16'h002D);
    chk("R6 state", {req_pri, req_sec, isr_pri, isr_sec}, {8'h00, 8'h00, 8'h04, 8'h20});

    // R8 edge deassert ignored, R12 level write
    clear_both();
    do_assert(4'd3);
    do_deassert(4'd3);
    chk("R8 edge keeps", req_pri, 8'h08);
    lvl_we = 1; lvl_sel = 0; lvl_din = 8'h08;
    @(negedge clk);
    lvl_we = 0;
    do_deassert(4'd3);
    chk("R12 R8 level clears", req_pri, 8'h00);

    // R8 secondary deassert and bit 2
    lvl_we = 1; lvl_sel = 1; lvl_din = 8'h03;
    @(negedge clk);
    lvl_we = 0;
    do_assert(4'd8);
    do_assert(4'd9);
    do_deassert(4'd8);
    chk("R8 sec partial", {req_pri, req_sec}, {8'h04, 8'h02});
    do_deassert(4'd9);
    chk("R8 sec empty", {req_pri, req_sec}, {8'h00, 8'h00});

    // R10 same-cycle assert and ack
    clear_both();
    assert_vld = 1; assert_line = 4'd5; ack_stb = 1;
    @(negedge clk);
    assert_vld = 0; ack_stb = 0;
    chk("R10 assert first", ack_vec, 16'h0025);

    // R5 no 8-bit wrap
    clear_both();
    base_pri = 8'hFE; low_pri = 3'd6;
    do_assert(4'd7);
    do_ack();
    chk("R5 wide sum", ack_vec, 16'h0105);
    base_pri = 8'h20; low_pri = 3'd7;

    // R11 one-sided clear
    clear_both();
    do_assert(4'd10);
    do_ack();
    do_assert(4'd1);
    do_assert(4'd11);
    clr_sec = 1;
    @(negedge clk);
    clr_sec = 0;
    chk("R11 sec cleared", {req_sec, isr_sec}, 16'h0000);
    chk("R11 pri kept", {req_pri, isr_pri}, {8'h06, 8'h04});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule